// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned operands with an array of AND gates and full adders and no behavioural multiply operator. Each partial-product bit is the AND of one multiplicand bit and one multiplier bit. The rows of partial products are summed one per pipeline stage by a row of full adders in carry-save form. A final ripple-carry row then merges the remaining sum and carry vectors.

Registers split the array into nine stages, so a new operand pair is taken on every clock. The multiplicand and multiplier travel with each operation, which gives later rows the bits they need while younger operations follow behind. A valid flag rides alongside each operation. A caller marks an operand pair with `in_valid` and takes the product when `out_valid` is high.

Top module: `pipe_array_mult`

## Requirements
- R1: When `out_valid` is high, `product` equals the unsigned 16-bit product of the operands that were accepted with that result, for every one of the 65536 operand pairs.
- R2: The result of a pair sampled with `in_valid` high on a rising edge is on the outputs just after the ninth rising edge, counting the sampling edge as the first.
- R3: One pair can be accepted on every clock. A back-to-back batch of N pairs yields exactly N results on N consecutive cycles, in the order the pairs were given.
- R4: Idle cycles between accepted pairs show up as cycles with `out_valid` low, at the same spacing, nine edges later.
- R5: `rst` is synchronous and active high. It clears every valid flag in the pipe, so operations in flight when reset is applied never produce a result.
- R6: Operands presented while `in_valid` is low are ignored. They produce no cycle with `out_valid` high.
- R7: A zero in either operand gives a product of 0.
- R8: 255 × 255 gives 65025, and 1 × x and x × 1 give x.
- R9: The final carry-propagate row never produces a carry out of the top bit for a valid operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `mcand`/`mplier` as an operation to accept |
| mcand | input | 8 | Unsigned multiplicand |
| mplier | input | 8 | Unsigned multiplier |
| out_valid | output | 1 | `product` holds a finished result |
| product | output | 16 | Unsigned product |

## Verification
The assertions take for granted that `rst` is held high over at least one rising edge before the first operation, and that `in_valid` is never unknown once reset is released. They also assume the operands are known whenever `in_valid` is high, since the exact-product check multiplies the operands carried with each operation. The stimulus holds reset from time zero and changes every input only on falling edges. It always drives the operands with defined values, including while `in_valid` is low.

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;

    parameter int OPW = 8;

    localparam int PRODW = 2 * OPW;
    localparam int NSTG  = OPW + 1;

    typedef logic [OPW-1:0]   word_t;
    typedef logic [PRODW-1:0] prod_t;

    // Carry-save state of one in-flight operation between rows
    typedef struct packed {
        logic  vld;
        word_t mcand;
        word_t mplier;
        word_t sum;    // already shifted right by one: aligned to the next row
        word_t cry;    // carry vector, weight of column j plus one
        word_t lo;     // retired low product bits
    } stage_t;

    // One row of AND gates: multiplicand gated by a single multiplier bit
    function automatic word_t pp_row(word_t mc, logic mbit);
        return mc & {OPW{mbit}};
    endfunction

endpackage

// File: rtl/ma_full_adder.sv
module ma_full_adder (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/ma_csa_row.sv
module ma_csa_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    for (genvar j = 0; j < W; j++) begin : g_fa
        ma_full_adder u_fa (
            .a (x[j]),
            .b (y[j]),
            .ci(z[j]),
            .s (s[j]),
            .co(c[j])
        );
    end
endmodule

// File: rtl/ma_ripple_add.sv
module ma_ripple_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar j = 0; j < W; j++) begin : g_fa
        ma_full_adder u_fa (
            .a (x[j]),
            .b (y[j]),
            .ci(chain[j]),
            .s (sum[j]),
            .co(chain[j+1])
        );
    end

    assign cout = chain[W];
endmodule

// File: rtl/pipe_array_mult.sv
module pipe_array_mult
    import mulpipe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [OPW-1:0]       mcand,
    input  logic [OPW-1:0]       mplier,
    output logic                 out_valid,
    output logic [PRODW-1:0]     product
);

    // Stages 0 .. OPW-1 hold carry-save state; one more register holds the result
    stage_t stg [OPW];
    stage_t nxt [OPW];

    // ---------------- stage 0: first partial-product row ----------------
    word_t pp0;
    assign pp0 = pp_row(mcand, mplier[0]);

    assign nxt[0] = '{vld:    in_valid,
                      mcand:  mcand,
                      mplier: mplier,
                      sum:    {1'b0, pp0[OPW-1:1]},
                      cry:    '0,
                      lo:     word_t'(pp0[0])};

    // ---------------- stages 1 .. OPW-1: one full-adder row each --------
    for (genvar i = 1; i < OPW; i++) begin : g_row
        word_t pp_i;
        word_t s_i;
        word_t c_i;

        assign pp_i = pp_row(stg[i-1].mcand, stg[i-1].mplier[i]);

        ma_csa_row #(.W(OPW)) u_row (
            .x(stg[i-1].sum),
            .y(pp_i),
            .z(stg[i-1].cry),
            .s(s_i),
            .c(c_i)
        );

        assign nxt[i] = '{vld:    stg[i-1].vld,
                          mcand:  stg[i-1].mcand,
                          mplier: stg[i-1].mplier,
                          sum:    {1'b0, s_i[OPW-1:1]},
                          cry:    c_i,
                          lo:     stg[i-1].lo | (word_t'(s_i[0]) << i)};

        AST_VALID_ADVANCE: assert property (@(posedge clk) disable iff (rst)
            stg[i-1].vld |=> stg[i].vld);                              // R3
        AST_BUBBLE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
            !stg[i-1].vld |=> !stg[i].vld);                            // R4
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '{default: '0};
        end else begin
            stg <= nxt;
        end
    end

    // ---------------- final stage: carry-propagate merge ----------------
    word_t hi;
    logic  top_cout;

    ma_ripple_add #(.W(OPW)) u_cpa (
        .x   (stg[OPW-1].sum),
        .y   (stg[OPW-1].cry),
        .sum (hi),
        .cout(top_cout)
    );

    logic  vld_q;
    prod_t prod_q;
    word_t mc_q;
    word_t mp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            prod_q <= '0;
            mc_q   <= '0;
            mp_q   <= '0;
        end else begin
            vld_q  <= stg[OPW-1].vld;
            prod_q <= {hi, stg[OPW-1].lo};
            mc_q   <= stg[OPW-1].mcand;
            mp_q   <= stg[OPW-1].mplier;
        end
    end

    assign out_valid = vld_q;
    assign product   = prod_q;

    // ---------------- assertions ----------------------------------------
    AST_NO_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
        stg[OPW-1].vld |-> !top_cout);                                  // R9
    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (prod_q == PRODW'(mc_q) * PRODW'(mp_q)));             // R1
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (vld_q && (mc_q == '0 || mp_q == '0)) |-> (prod_q == '0));      // R7
    AST_LAST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        stg[OPW-1].vld |=> vld_q);                                      // R2
    AST_IDLE_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !stg[0].vld);                                     // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!vld_q && !stg[0].vld));                               // R5

endmodule

// File: tb/pipe_array_mult_tb.sv
module pipe_array_mult_tb_top;

    localparam int W   = 8;
    localparam int PW  = 16;
    localparam int LAT = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  a = '0;
    logic [W-1:0]  b = '0;
    logic          out_valid;
    logic [PW-1:0] product;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    pipe_array_mult dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .mcand    (a),
        .mplier   (b),
        .out_valid(out_valid),
        .product  (product)
    );

    // Expected-result delay line built from the requirements (R2: nine edges)
    logic          ev [1:LAT];
    logic [PW-1:0] ep [1:LAT];

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 1; k <= LAT; k++) ev[k] <= 1'b0;
        end else begin
            ev[1] <= in_valid;
            for (int k = 2; k <= LAT; k++) ev[k] <= ev[k-1];
        end
        ep[1] <= PW'(a) * PW'(b);
        for (int k = 2; k <= LAT; k++) ep[k] <= ep[k-1];
    end

    task automatic step(input string req);
        @(negedge clk);
        n_tests++;
        if (out_valid !== ev[LAT] || (ev[LAT] && product !== ep[LAT])) begin
            n_fail++;
            $display("FAIL %s: out_valid=%0b product=%0d, expected out_valid=%0b product=%0d",
                     req, out_valid, product, ev[LAT], ep[LAT]);
        end
    endtask

    task automatic drive(input logic v, input logic [W-1:0] x, input logic [W-1:0] y,
                         input string req);
        in_valid = v;
        a = x;
        b = y;
        step(req);
    endtask

    task automatic expect_int(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drain(input string req);
        for (int k = 0; k < LAT + 1; k++) drive(1'b0, 8'hA5, 8'h5A, req);
    endtask

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    // R5: reset holds the pipe empty even with in_valid high
    task automatic t_reset();
        rst = 1'b1;
        for (int k = 0; k < 3; k++) drive(1'b1, 8'd200, 8'd3, "R5 reset");
        expect_int("R5 out_valid under reset", int'(out_valid), 0);
        rst = 1'b0;
        drain("R5 after reset");
    endtask

    // R2: count edges from acceptance to result
    task automatic t_latency();
        int n;
        drive(1'b1, 8'd13, 8'd11, "R2 launch");
        n = 1;
        while (out_valid !== 1'b1 && n < 20) begin
            drive(1'b0, 8'd0, 8'd0, "R2 wait");
            n++;
        end
        expect_int("R2 edges to result", n, LAT);
        expect_int("R2 product 13*11", int'(product), 143);
        drain("R2 drain");
    endtask

    // R7, R8: corner operands
    task automatic t_corners();
        drive(1'b1, 8'd0,   8'd173, "R7 0*x");
        drive(1'b1, 8'd94,  8'd0,   "R7 x*0");
        drive(1'b1, 8'd255, 8'd255, "R8 255*255");
        drive(1'b1, 8'd1,   8'd201, "R8 1*x");
        drive(1'b1, 8'd77,  8'd1,   "R8 x*1");
        drive(1'b1, 8'd0,   8'd0,   "R7 0*0");
        for (int k = 0; k < LAT - 6; k++) drive(1'b0, 8'd9, 8'd9, "R7 drain");
        // first corner result is now on the outputs
        expect_int("R7 0*x product", int'(product), 0);
        drive(1'b0, 8'd9, 8'd9, "R7 drain");
        drive(1'b0, 8'd9, 8'd9, "R8 drain");
        expect_int("R8 255*255 product", int'(product), 65025);
        drive(1'b0, 8'd9, 8'd9, "R8 drain");
        expect_int("R8 1*x product", int'(product), 201);
        drain("R8 drain");
    endtask

    // R6: operands without in_valid never produce a result
    task automatic t_ignored();
        int seen = 0;
        for (int k = 0; k < 3 * LAT; k++) begin
            drive(1'b0, 8'(k * 7 + 3), 8'(k * 13 + 1), "R6 idle operands");
            if (out_valid === 1'b1) seen++;
        end
        expect_int("R6 results from idle cycles", seen, 0);
    endtask

    // R3: back-to-back batches
    task automatic t_batches();
        int sizes [6] = '{1, 5, 10, 100, 500, 1000};
        foreach (sizes[s]) begin
            int seen = 0;
            for (int k = 0; k < sizes[s]; k++) begin
                seed = lcg(seed);
                drive(1'b1, seed[23:16], seed[15:8], "R3 batch");
                if (out_valid === 1'b1) seen++;
            end
            for (int k = 0; k < LAT + 1; k++) begin
                drive(1'b0, 8'hFF, 8'hFF, "R3 batch drain");
                if (out_valid === 1'b1) seen++;
            end
            expect_int("R3 results per batch", seen, sizes[s]);
        end
    endtask

    // R4: gaps between operations are preserved
    task automatic t_gaps();
        for (int k = 0; k < 40; k++) begin
            seed = lcg(seed);
            drive(((k % 3) != 1), seed[31:24], seed[7:0], "R4 gapped stream");
        end
        drain("R4 drain");
    endtask

    // R5: reset in mid-flight discards queued operations
    task automatic t_midreset();
        int seen = 0;
        for (int k = 0; k < 5; k++) drive(1'b1, 8'(k + 10), 8'(k + 20), "R5 launch");
        rst = 1'b1;
        drive(1'b0, 8'd0, 8'd0, "R5 mid reset");
        rst = 1'b0;
        for (int k = 0; k < LAT + 2; k++) begin
            drive(1'b0, 8'd0, 8'd0, "R5 after mid reset");
            if (out_valid === 1'b1) seen++;
        end
        expect_int("R5 results surviving reset", seen, 0);
    endtask

    // R1: every operand pair
    task automatic t_exhaustive();
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                drive(1'b1, 8'(x), 8'(y), "R1 exhaustive");
            end
        end
        drain("R1 drain");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_corners();
        t_ignored();
        t_batches();
        t_gaps();
        t_midreset();
        t_exhaustive();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule